// File: doc/BRIEF.md
# Clock Source Mux and Post-Divider Bank

This block produces four divided clock outputs, channels A to D, from a small set of source clocks. Each channel picks one source and divides it by an integer between 1 and 50. Channel C and channel D each hold two complete configurations, and a select pin chooses which one is live. The block runs on a fast system clock. Each source is a level signal that toggles slower than half the system clock rate. Sources are registered once, and the rising edges of the selected source drive each channel's counter.

Register values arrive through a parallel write port, one channel configuration per address. A channel takes a new source or divide value only when its current output period ends, so a change never produces a short pulse. A power-down input forces every output low and clears every counter. A separate output-enable signal is passed to the pad drivers to put the outputs in a high-impedance state for board testing.

Top module: `cmdiv_bank`

## Requirements
- R1: After reset, all six configuration entries hold source 0 and divide 2, and every clock output is low.
- R2: With divide value n, a running channel's output period is exactly n periods of its selected source. A period begins on a rising edge of that source, and the output shows it two system clock edges later.
- R3: For an even n, the output is high for n/2 source periods and low for n/2, which gives a 50% duty cycle.
- R4: For an odd n of 3 or more, the output is high for (n+1)/2 source periods and low for (n-1)/2.
- R5: For n = 1, the output follows the selected source level with a delay of two system clock edges.
- R6: A written divide field of 0 is stored as 1, and a value above 50 is stored as 50.
- R7: Write address 0 configures channel A and address 1 configures channel B. Addresses 2 and 3 are channels C and D in set 0, and addresses 4 and 5 are channels C and D in set 1. Data bits [7:6] carry the source index and bits [5:0] carry the divide value. Writes to addresses 6 and 7 have no effect.
- R8: When sel_cd_i is high, channels C and D use set 1. When it is low, they use set 0. Channels A and B do not depend on the select.
- R9: A change of source or divide value takes effect only at the selected-source rising edge that ends the current output period, so no pulse shorter than the programmed phases appears.
- R10: While pd_i is high, all clock outputs are low in the same cycle and all counters are cleared. After release, each output stays low until the first rising edge of its selected source, then begins a new period with its high phase.
- R11: clk_oe_o follows oe_i on all four channels, whether or not power-down is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 4 | Source clock levels |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Configuration entry address |
| wr_data_i | input | 8 | Source index [7:6] and divide value [5:0] |
| sel_cd_i | input | 1 | Configuration set select for channels C and D |
| pd_i | input | 1 | Power-down |
| oe_i | input | 1 | Output enable request |
| clk_o | output | 4 | Divided clocks, bit 0 is channel A |
| clk_oe_o | output | 4 | Pad driver enables, low for high impedance |

## Verification
The bench builds the block with the reset divide value of 2 and the package limit of 50. It runs the four sources with periods of 4, 6, 10 and 2 system cycles. The 2-cycle source brings the full 50x divide within reach in 100-cycle output periods. The other sources give distinct even, odd and pass-through period and duty measurements. The behavioural model runs every cycle, so configuration changes in mid-period, select flips and power-down release are all compared edge by edge.

// File: rtl/cmdiv_pkg.sv
package cmdiv_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int DIV_W     = 6;
  localparam int DIV_MAX   = 50;
  localparam int NUM_CH    = 4;
  localparam int NUM_FIXED = 2;                               // channels without a second set
  localparam int SET0_BASE = NUM_FIXED;
  localparam int SET1_BASE = NUM_FIXED + (NUM_CH - NUM_FIXED);
  localparam int NUM_REG   = NUM_FIXED + 2 * (NUM_CH - NUM_FIXED);
  localparam int ADDR_W    = $clog2(NUM_REG + 1);
  localparam int DATA_W    = SRC_W + DIV_W;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } ch_cfg_t;

  function automatic ch_cfg_t decode_cfg(input logic [DATA_W-1:0] d);
    ch_cfg_t c;
    c.src = d[DATA_W-1:DIV_W];
    c.div = d[DIV_W-1:0];
    if (c.div == '0) c.div = DIV_W'(1);
    else if (c.div > DIV_W'(DIV_MAX)) c.div = DIV_W'(DIV_MAX);
    return c;
  endfunction
endpackage

// File: rtl/cmdiv_regs.sv
module cmdiv_regs
  import cmdiv_pkg::*;
#(
  parameter int RST_DIV = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       sel_i,
  output ch_cfg_t [NUM_CH-1:0]       req_o
);
  ch_cfg_t [NUM_REG-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REG; i++) reg_q[i] <= '{src: '0, div: DIV_W'(RST_DIV)};
    end else if (wr_en_i && (wr_addr_i < ADDR_W'(NUM_REG))) begin
      reg_q[wr_addr_i] <= decode_cfg(wr_data_i);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_req
    if (ch < NUM_FIXED) begin : g_fixed
      assign req_o[ch] = reg_q[ch];
    end else begin : g_sel
      assign req_o[ch] = sel_i ? reg_q[SET1_BASE + ch - NUM_FIXED]
                               : reg_q[SET0_BASE + ch - NUM_FIXED];
    end
  end
endmodule

// File: rtl/cmdiv_chan.sv
module cmdiv_chan
  import cmdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  ch_cfg_t            req_i,
  output logic               clk_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  ch_cfg_t          act_q;
  logic [DIV_W-1:0] cnt_q;
  logic             run_q;
  logic             out_q;

  logic             rise_act, rise_req, last, bnd;
  logic [DIV_W-1:0] cnt_nx;
  logic [DIV_W:0]   hi_len;

  always_comb begin
    rise_act = rise_i[act_q.src];
    rise_req = rise_i[req_i.src];
    last     = (cnt_q == act_q.div - ONE);
    bnd      = run_q ? (rise_act && last) : rise_req;
    cnt_nx   = cnt_q + ONE;
    hi_len   = ((DIV_W+1)'(act_q.div) + (DIV_W+1)'(1)) >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '{src: '0, div: ONE};
      cnt_q <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else if (pd_i) begin
      act_q <= req_i;
      cnt_q <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else if (bnd) begin
      // period boundary: adopt pending config, start high phase
      act_q <= req_i;
      cnt_q <= '0;
      run_q <= 1'b1;
      out_q <= 1'b1;
    end else if (!run_q) begin
      act_q <= req_i;
    end else if (act_q.div == ONE) begin
      out_q <= lvl_i[act_q.src];
    end else if (rise_act) begin
      cnt_q <= cnt_nx;
      out_q <= ({1'b0, cnt_nx} < hi_len);
    end
  end

  assign clk_o = out_q;

  // R10
  pd_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !out_q);

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && run_q && !bnd) |=> $stable(act_q));

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < act_q.div));

  // R2
  bnd_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && !pd_i) |=> (cnt_q == '0 && out_q && run_q));

  // R6
  req_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.div != '0) && (req_i.div <= DIV_W'(DIV_MAX)));
endmodule

// File: rtl/cmdiv_bank.sv
module cmdiv_bank
  import cmdiv_pkg::*;
#(
  parameter int RST_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               sel_cd_i,
  input  logic               pd_i,
  input  logic               oe_i,
  output logic [NUM_CH-1:0]  clk_o,
  output logic [NUM_CH-1:0]  clk_oe_o
);
  logic [NUM_SRC-1:0] src_q, src_qq, src_rise;
  ch_cfg_t [NUM_CH-1:0] req;
  logic [NUM_CH-1:0] ch_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      src_qq <= '0;
    end else begin
      src_q  <= src_i;
      src_qq <= src_q;
    end
  end

  assign src_rise = src_q & ~src_qq;

  cmdiv_regs #(.RST_DIV(RST_DIV)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sel_i     (sel_cd_i),
    .req_o     (req)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    cmdiv_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pd_i   (pd_i),
      .lvl_i  (src_q),
      .rise_i (src_rise),
      .req_i  (req[ch]),
      .clk_o  (ch_out[ch])
    );
  end

  // power-down masks outputs in the same cycle
  assign clk_o    = ch_out & {NUM_CH{~pd_i}};
  assign clk_oe_o = {NUM_CH{oe_i}};
endmodule

// File: tb/cmdiv_bank_tb_top.sv
module cmdiv_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sel_cd = 1'b1;
  logic       pd = 1'b0;
  logic       oe = 1'b1;
  logic [3:0] clk_out, clk_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cmdiv_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sel_cd_i(sel_cd),
    .pd_i(pd), .oe_i(oe), .clk_o(clk_out), .clk_oe_o(clk_oe)
  );

  // sources: half periods 2,3,5,1 -> periods 4,6,10,2
  int half[4] = '{2, 3, 5, 1};
  initial begin
    int sc[4] = '{0, 0, 0, 0};
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (sc[k] == half[k] - 1) begin src[k] = ~src[k]; sc[k] = 0; end
        else sc[k]++;
      end
    end
  end

  // behavioural reference
  int m_src[6], m_div[6];
  int a_src[4], a_div[4], cnt[4];
  bit run[4], mout[4], ms_q[4], ms_qq[4];

  function automatic int req_idx(int ch);
    if (ch < 2) return ch;
    return sel_cd ? ch + 2 : ch;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin m_src[i] = 0; m_div[i] = 2; end
    for (int c = 0; c < 4; c++) begin
      a_src[c] = 0; a_div[c] = 1; cnt[c] = 0; run[c] = 0; mout[c] = 0;
      ms_q[c] = 0; ms_qq[c] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int c = 0; c < 4; c++) begin
        int ri, rs, rd;
        bit rise;
        ri = req_idx(c); rs = m_src[ri]; rd = m_div[ri];
        if (pd) begin
          run[c] = 0; cnt[c] = 0; mout[c] = 0; a_src[c] = rs; a_div[c] = rd;
        end else if (!run[c]) begin
          if (ms_q[rs] && !ms_qq[rs]) begin run[c] = 1; cnt[c] = 0; mout[c] = 1; end
          a_src[c] = rs; a_div[c] = rd;
        end else begin
          rise = ms_q[a_src[c]] && !ms_qq[a_src[c]];
          if (rise && (a_div[c] == 1 || cnt[c] == a_div[c] - 1)) begin
            a_src[c] = rs; a_div[c] = rd; cnt[c] = 0; mout[c] = 1;
          end else if (a_div[c] == 1) mout[c] = ms_q[a_src[c]];
          else if (rise) begin
            cnt[c]++;
            mout[c] = (cnt[c] < (a_div[c] + 1) / 2);
          end
        end
      end
      if (wr_en && wr_addr < 6) begin
        int d;
        d = int'(wr_data[5:0]);
        if (d == 0) d = 1;
        else if (d > 50) d = 50;
        m_src[wr_addr] = int'(wr_data[7:6]);
        m_div[wr_addr] = d;
      end
      for (int k = 0; k < 4; k++) begin ms_qq[k] = ms_q[k]; ms_q[k] = src[k]; end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle compare against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] exp;
      for (int c = 0; c < 4; c++) exp[c] = mout[c] & ~pd;
      check(clk_out === exp, "R9 model", int'(clk_out), int'(exp));
      check(clk_oe === {4{oe}}, "R11 oe", int'(clk_oe), int'({4{oe}}));
    end
  end

  task automatic wr(int addr, int src_sel, int dv);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = {2'(src_sel), 6'(dv)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(int ch);
    logic p;
    p = clk_out[ch];
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!p && clk_out[ch]) return;
      p = clk_out[ch];
    end
  endtask

  task automatic measure(int ch, int per, int hi, string req);
    int t, h;
    logic cur, prv;
    wait_rise(ch);
    wait_rise(ch);
    t = 0; h = 0; cur = clk_out[ch];
    do begin
      h += int'(cur); t++; prv = cur;
      @(negedge clk);
      cur = clk_out[ch];
    end while (!(cur && !prv) && t < 2000);
    check(t == per, {req, " period"}, t, per);
    check(h == hi, {req, " high"}, h, hi);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(clk_out === 4'b0, "R1 reset out", int'(clk_out), 0);
    rst_n = 1'b1;
    // R1: defaults are src0 div2 -> period 8, high 4
    measure(0, 8, 4, "R1 chA default");
    measure(3, 8, 4, "R1 chD default");
    // R4: src1 (6) div3
    wr(0, 1, 3);
    measure(0, 18, 12, "R4 odd div3");
    // R2 R3: src3 (2) div50
    wr(1, 3, 50);
    measure(1, 100, 50, "R2 max div50");
    // R3: src2 (10) div4
    wr(0, 2, 4);
    measure(0, 40, 20, "R3 even div4");
    // R5 R6: div 0 -> 1 on src1
    wr(0, 1, 0);
    measure(0, 6, 3, "R5 R6 div0 passthrough");
    // R6: div 63 -> 50 on src3
    wr(1, 3, 63);
    measure(1, 100, 50, "R6 clamp 63");
    // R7 R8: C set0 src1 div3, C set1 src0 div5, D set0 src2 div2
    wr(2, 1, 3);
    wr(4, 0, 5);
    wr(3, 2, 2);
    sel_cd = 1'b1;
    measure(2, 20, 12, "R8 chC set1");
    measure(3, 8, 4, "R8 chD set1");
    sel_cd = 1'b0;
    measure(2, 18, 12, "R8 chC set0");
    measure(3, 20, 10, "R8 chD set0");
    measure(0, 6, 3, "R8 chA unaffected");
    // R7: writes to 6 and 7 ignored
    wr(6, 2, 7);
    wr(7, 2, 9);
    measure(0, 6, 3, "R7 ignored addr chA");
    measure(2, 18, 12, "R7 ignored addr chC");
    // R9: change mid-period, model compare covers each edge
    wr(0, 0, 7);
    measure(0, 28, 16, "R9 switch div7");
    // R10: power-down
    @(negedge clk);
    pd = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(clk_out === 4'b0, "R10 pd low", int'(clk_out), 0);
      check(clk_oe === 4'hf, "R11 oe during pd", int'(clk_oe), 15);
    end
    pd = 1'b0;
    measure(0, 28, 16, "R10 restart chA");
    measure(1, 100, 50, "R10 restart chB");
    // R11
    @(negedge clk);
    oe = 1'b0;
    @(negedge clk);
    check(clk_oe === 4'b0, "R11 oe low", int'(clk_oe), 0);
    oe = 1'b1;
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule